// File: doc/BRIEF.md
# UART Hardware Flow Controller

This block makes the modem handshake lines of a UART run without software. On the receive side it drives the active-low RTS pin from the receive FIFO occupancy. RTS goes high (stop) once the FIFO reaches the selected trigger level. It goes low again only after the FIFO has drained to the next lower trigger level. This gap leaves room for the one extra character that a remote sender may already have started after RTS rose.

On the transmit side, the block gives the shift register permission to begin a character only while the synchronized CTS pin is low. The transmitter presents `tx_ready_i` only at a character boundary, so a CTS change in the middle of a character affects only the next start bit.

The block also holds the RTS control bit. With auto-RTS off, the pin follows this bit. With auto-RTS on, the bit becomes a read-only copy of the pin's asserted state.

Top module: `uart_flow_ctl`

## Requirements
- R1: During and after reset, with no other stimulus, `rts_no` is 1 and `rts_ctl_o` is 0.
- R2: Trigger select codes map to FIFO levels as follows: 0 is 1, 1 is 4, 2 is 8 and 3 is 14. With auto-RTS on, a count at or above the selected level drives `rts_no` to 1 after the next rising clock edge.
- R3: With auto-RTS on, `rts_no` keeps its value while the count lies strictly between the lower level and the selected level.
- R4: With auto-RTS on, a count at or below the lower level drives `rts_no` to 0 after the next edge. The lower level is the level of the select code one below the current one. For code 0 the lower level is 0, so the FIFO must be empty.
- R5: With auto-RTS off, a write strobe loads `rts_wdata_i` into the control bit at the next edge. One edge later `rts_no` equals the inverse of that bit (1 in the bit means RTS asserted low).
- R6: With auto-RTS on, `rts_ctl_o` equals the inverse of `rts_no` and write strobes are ignored. After auto-RTS is cleared, the bit keeps the last copied value, so the pin does not change.
- R7: With auto-CTS off, `tx_start_o` equals `tx_ready_i`.
- R8: With auto-CTS on, `tx_start_o` is 1 only when `tx_ready_i` is 1 and the CTS pin, sampled through two flops, is 0. A CTS change therefore shows on `tx_start_o` after two rising edges.
- R9: `tx_start_o` is never 1 while `tx_ready_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| trig_sel_i | input | 2 | Trigger level select code |
| auto_rts_en_i | input | 1 | Hardware control of RTS |
| auto_cts_en_i | input | 1 | Gate transmit start on CTS |
| rts_wr_i | input | 1 | Write strobe for the RTS control bit |
| rts_wdata_i | input | 1 | Value to write (1 asserts RTS) |
| cts_ni | input | 1 | CTS pin, asynchronous, active low |
| tx_ready_i | input | 1 | Shift register at a boundary with a byte ready |
| rts_no | output | 1 | RTS pin, active low, registered |
| rts_ctl_o | output | 1 | Readback of the RTS control bit |
| tx_start_o | output | 1 | Permission to start a character |

## Verification
The bench uses the default 16-entry depth, which gives a 5-bit count. This makes it possible to sweep every count from 0 to 16 upward and then downward under all four trigger codes, which reaches every deassert, hold and reassert boundary. The transmit gate is driven through all eight combinations of auto-CTS, ready and CTS. A separate step checks the two-edge synchronizer latency. Further sequences cover write masking in auto mode and a handover out of auto mode with no glitch on the pin.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
  localparam int unsigned SEL_W = 2;

  function automatic int unsigned lvl_of(input logic [SEL_W-1:0] sel,
                                         input int unsigned l0, input int unsigned l1,
                                         input int unsigned l2, input int unsigned l3);
    case (sel)
      2'd0:    return l0;
      2'd1:    return l1;
      2'd2:    return l2;
      default: return l3;
    endcase
  endfunction

  // level one code below; code 0 means empty
  function automatic int unsigned lower_of(input logic [SEL_W-1:0] sel,
                                           input int unsigned l0, input int unsigned l1,
                                           input int unsigned l2, input int unsigned l3);
    if (sel == '0) return 0;
    return lvl_of(sel - 1'b1, l0, l1, l2, l3);
  endfunction
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rts_hyst.sv
module rts_hyst
  import uart_flow_pkg::*;
#(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LVL0  = 1,
  parameter int unsigned LVL1  = 4,
  parameter int unsigned LVL2  = 8,
  parameter int unsigned LVL3  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wr_i,
  input  logic             wdata_i,
  output logic             rts_no,
  output logic             ctl_o
);
  logic [CNT_W-1:0] hi_lvl, lo_lvl;
  logic             pin_d, pin_q, ctl_d, ctl_q;

  always_comb begin
    hi_lvl = CNT_W'(lvl_of(sel_i, LVL0, LVL1, LVL2, LVL3));
    lo_lvl = CNT_W'(lower_of(sel_i, LVL0, LVL1, LVL2, LVL3));
  end

  always_comb begin
    if (auto_i) begin
      if (count_i >= hi_lvl)      pin_d = 1'b1;
      else if (count_i <= lo_lvl) pin_d = 1'b0;
      else                        pin_d = pin_q;
      ctl_d = ~pin_d;             // mirror keeps handover glitch-free
    end else begin
      pin_d = ~ctl_q;
      ctl_d = wr_i ? wdata_i : ctl_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b1;
      ctl_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      ctl_q <= ctl_d;
    end
  end

  assign rts_no = pin_q;
  assign ctl_o  = ctl_q;
endmodule

// File: rtl/tx_gate.sv
module tx_gate (
  input  logic auto_i,
  input  logic cts_sync_ni,
  input  logic ready_i,
  output logic start_o
);
  assign start_o = ready_i & (~auto_i | ~cts_sync_ni);
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import uart_flow_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LVL0        = 1,
  parameter int unsigned LVL1        = 4,
  parameter int unsigned LVL2        = 8,
  parameter int unsigned LVL3        = 14,
  localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [SEL_W-1:0] trig_sel_i,
  input  logic             auto_rts_en_i,
  input  logic             auto_cts_en_i,
  input  logic             rts_wr_i,
  input  logic             rts_wdata_i,
  input  logic             cts_ni,
  input  logic             tx_ready_i,
  output logic             rts_no,
  output logic             rts_ctl_o,
  output logic             tx_start_o
);
  logic cts_s_n;

  rts_hyst #(
    .CNT_W(CNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_rts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .auto_i  (auto_rts_en_i),
    .count_i (rx_count_i),
    .sel_i   (trig_sel_i),
    .wr_i    (rts_wr_i),
    .wdata_i (rts_wdata_i),
    .rts_no  (rts_no),
    .ctl_o   (rts_ctl_o)
  );

  cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cts_ni),
    .q_o    (cts_s_n)
  );

  tx_gate u_gate (
    .auto_i      (auto_cts_en_i),
    .cts_sync_ni (cts_s_n),
    .ready_i     (tx_ready_i),
    .start_o     (tx_start_o)
  );
endmodule

// File: rtl/uart_flow_ctl_chk.sv
module uart_flow_ctl_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [1:0]       trig_sel_i,
  input logic             auto_rts_en_i,
  input logic             auto_cts_en_i,
  input logic             cts_ni,
  input logic             tx_ready_i,
  input logic             rts_no,
  input logic             rts_ctl_o,
  input logic             tx_start_o
);
  logic [CNT_W-1:0] hi, lo;
  always_comb begin
    case (trig_sel_i)
      2'd0: begin hi = CNT_W'(1);  lo = CNT_W'(0); end
      2'd1: begin hi = CNT_W'(4);  lo = CNT_W'(1); end
      2'd2: begin hi = CNT_W'(8);  lo = CNT_W'(4); end
      default: begin hi = CNT_W'(14); lo = CNT_W'(8); end
    endcase
  end

  assert_stop_at_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && rx_count_i >= hi) |=> rts_no);

  assert_hold_in_band_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && rx_count_i > lo && rx_count_i < hi) |=> $stable(rts_no));

  assert_go_at_lower_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && rx_count_i <= lo) |=> !rts_no);

  assert_manual_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i |=> (rts_no == !$past(rts_ctl_o)));

  assert_mirror_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_rts_en_i |=> (rts_ctl_o == !rts_no));

  assert_cts_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_cts_en_i && cts_ni && $past(cts_ni) && $past(cts_ni, 2)) |-> !tx_start_o);

  assert_no_start_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ready_i |-> !tx_start_o);
endmodule

bind uart_flow_ctl uart_flow_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_count_i    (rx_count_i),
  .trig_sel_i    (trig_sel_i),
  .auto_rts_en_i (auto_rts_en_i),
  .auto_cts_en_i (auto_cts_en_i),
  .cts_ni        (cts_ni),
  .tx_ready_i    (tx_ready_i),
  .rts_no        (rts_no),
  .rts_ctl_o     (rts_ctl_o),
  .tx_start_o    (tx_start_o)
);

// File: tb/uart_flow_ctl_test.sv
module uart_flow_ctl_test;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [CW-1:0] rx_count_i = '0;
  logic [1:0] trig_sel_i = '0;
  logic auto_rts_en_i = 1'b0, auto_cts_en_i = 1'b0;
  logic rts_wr_i = 1'b0, rts_wdata_i = 1'b0, cts_ni = 1'b1, tx_ready_i = 1'b0;
  logic rts_no, rts_ctl_o, tx_start_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  uart_flow_ctl uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lvl(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  function automatic int lowr(input int s);
    return (s == 0) ? 0 : lvl(s - 1);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    int exp_pin;
    tick(2);
    chk("R1 rts in reset", rts_no, 1);
    rst_ni = 1'b1;
    tick(2);
    chk("R1 rts after reset", rts_no, 1);
    chk("R1 ctl after reset", rts_ctl_o, 0);

    // hysteresis sweep
    auto_rts_en_i = 1'b1;
    for (int s = 0; s < 4; s++) begin
      trig_sel_i = 2'(s);
      rx_count_i = '0;
      tick(1);
      exp_pin = 0;
      chk("R4 empty start", rts_no, 0);
      for (int c = 0; c <= DEPTH; c++) begin
        rx_count_i = CW'(c);
        tick(1);
        if (c >= lvl(s)) exp_pin = 1;
        else if (c <= lowr(s)) exp_pin = 0;
        chk((c >= lvl(s)) ? "R2 up ramp" : "R3 up ramp", rts_no, exp_pin);
      end
      for (int c = DEPTH; c >= 0; c--) begin
        rx_count_i = CW'(c);
        tick(1);
        if (c >= lvl(s)) exp_pin = 1;
        else if (c <= lowr(s)) exp_pin = 0;
        chk((c <= lowr(s)) ? "R4 down ramp" : "R3 down ramp", rts_no, exp_pin);
        chk("R6 mirror", rts_ctl_o, 1 - exp_pin);
      end
    end

    // writes ignored in auto mode
    trig_sel_i = 2'd3;
    rx_count_i = '0;
    tick(1);
    rts_wr_i = 1'b1; rts_wdata_i = 1'b0;
    tick(1);
    rts_wr_i = 1'b0;
    tick(1);
    chk("R6 write ignored ctl", rts_ctl_o, 1);
    chk("R6 write ignored pin", rts_no, 0);
    rx_count_i = CW'(14);
    tick(1);
    chk("R2 level 14", rts_no, 1);
    auto_rts_en_i = 1'b0;
    tick(1);
    chk("R6 handover pin", rts_no, 1);
    chk("R6 handover ctl", rts_ctl_o, 0);
    tick(2);
    chk("R6 handover stays", rts_no, 1);

    // manual mode
    rts_wr_i = 1'b1; rts_wdata_i = 1'b1;
    tick(1);
    rts_wr_i = 1'b0;
    chk("R5 ctl loaded", rts_ctl_o, 1);
    chk("R5 pin lags", rts_no, 1);
    tick(1);
    chk("R5 pin follows", rts_no, 0);
    rx_count_i = CW'(16);
    tick(2);
    chk("R5 count ignored", rts_no, 0);
    rts_wr_i = 1'b1; rts_wdata_i = 1'b0;
    tick(1);
    rts_wr_i = 1'b0;
    tick(1);
    chk("R5 pin high", rts_no, 1);

    // transmit gate sweep
    for (int a = 0; a < 2; a++)
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 2; c++) begin
          auto_cts_en_i = a[0]; tx_ready_i = r[0]; cts_ni = c[0];
          tick(3);
          if (r == 0) chk("R9 gate", tx_start_o, 0);
          else if (a == 0) chk("R7 gate", tx_start_o, 1);
          else chk("R8 gate", tx_start_o, (c == 0) ? 1 : 0);
        end

    // synchronizer latency
    auto_cts_en_i = 1'b1; tx_ready_i = 1'b1; cts_ni = 1'b1;
    tick(3);
    cts_ni = 1'b0;
    tick(1);
    chk("R8 one edge", tx_start_o, 0);
    tick(1);
    chk("R8 two edges", tx_start_o, 1);
    cts_ni = 1'b1;
    tick(1);
    chk("R8 release one edge", tx_start_o, 1);
    tick(1);
    chk("R8 release two edges", tx_start_o, 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule